// File: doc/BRIEF.md
# GPIO Bank with Peripheral Override Muxing

This block is a bank of general-purpose I/O pins, one lane per pin and as many lanes as the `NPINS` parameter asks for. Software owns two register bits per pin: a direction bit and a port bit. When the pin is an output, the port bit is the level it drives. When the pin is an input, the port bit requests the pull-up. Software writes and reads these registers over a minimal strobe bus. The settled pin level comes back through a two-flop synchronizer and can be read on the same bus.

On-chip peripherals can take control of individual pins. Each pin has an enable/value pair for each of four things: the pull-up, the output driver enable, the driven value and the digital input enable. An enabled override replaces the register-derived setting. A per-pin toggle request inverts the stored port bit.

A global pull-up disable and a sleep indication complete the inputs. Outside sleep, the digital input is on by default. During sleep it is off, and a disabled input reads as 0. Peripherals also receive the gated pad level before the synchronizer, and must synchronize it themselves.

Top module: `gpio_ovr_bank`

## Requirements
- R1: While `rst_n` is low, all direction and port bits are 0, `pin_sync` is 0 and `rd_data` is 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the direction register when `wr_sel`=0, or into the port register when `wr_sel`=1, at that clock edge. Without a write or a toggle, both registers hold their value.
- R3: When a pin's `pu_ovr_en` bit is 0, `pad_pu` is 1 exactly when its direction bit is 0, its port bit is 1 and `pud` is 0.
- R4: When a pin's `pu_ovr_en` bit is 1, `pad_pu` equals `pu_ovr_val`. Direction, port and `pud` are ignored.
- R5: `pad_oe` equals `dd_ovr_val` when `dd_ovr_en` is 1, and the direction bit otherwise.
- R6: `pad_out` equals `pv_ovr_val` when both `pad_oe` and `pv_ovr_en` are 1, and the port bit otherwise.
- R7: In each cycle that a pin's `tgl_ovr_en` bit is 1, its port bit inverts at the clock edge. If a port write lands in the same cycle, the written value is stored and then inverted.
- R8: `pad_ie` equals `ie_ovr_val` when `ie_ovr_en` is 1, and the inverse of `sleep` otherwise. A pin whose `pad_ie` is 0 presents 0 on `periph_in` and to the synchronizer.
- R9: `periph_in` equals `pad_in` gated by `pad_ie` in the same cycle, with no register stage.
- R10: A gated pad level applied before clock edge k appears on `pin_sync` after edge k+1, which is two edges of latency.
- R11: A cycle with `rd_en` high loads `rd_data` at that edge from the selected source: `rd_sel`=0 gives direction, 1 gives port, 2 gives `pin_sync` and 3 gives 0. Without `rd_en`, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = direction, 1 = port |
| wr_data | input | NPINS | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read source: 0 = direction, 1 = port, 2 = pin level, 3 = zero |
| rd_data | output | NPINS | Registered read data |
| pud | input | 1 | Global pull-up disable |
| sleep | input | 1 | Sleep indication |
| pu_ovr_en | input | NPINS | Pull-up override enable |
| pu_ovr_val | input | NPINS | Pull-up override value |
| dd_ovr_en | input | NPINS | Driver enable override enable |
| dd_ovr_val | input | NPINS | Driver enable override value |
| pv_ovr_en | input | NPINS | Driven value override enable |
| pv_ovr_val | input | NPINS | Driven value override value |
| tgl_ovr_en | input | NPINS | Port bit toggle request |
| ie_ovr_en | input | NPINS | Input enable override enable |
| ie_ovr_val | input | NPINS | Input enable override value |
| pad_in | input | NPINS | Raw pad levels |
| pad_oe | output | NPINS | Pad driver enable |
| pad_out | output | NPINS | Pad output value |
| pad_pu | output | NPINS | Pull-up enable |
| pad_ie | output | NPINS | Digital input enable |
| periph_in | output | NPINS | Gated, unsynchronized pad level for peripherals |
| pin_sync | output | NPINS | Synchronized gated pad level |

## Verification
The bench sweeps every combination of the per-pin overrides, direction, port, `pud`, `sleep` and pad level, and checks the combinational pad controls against arithmetic expectations. Several mistakes would show up there:
- a pull-up that ignores `pud` or ignores an active override;
- a value override that still drives while the driver is disabled;
- an input gate that reads sleep while an override is active.

The toggle tests cover three cases: a single-cycle request, a request held for several cycles, and a toggle coinciding with a port write. A design that lets the write win, or toggles only once per assertion, stores the wrong port value. The synchronizer is probed one and two edges after a pad change, which catches a one-flop or three-flop path. The read path is checked for its hold behaviour and for the unused select code.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;
    // write target select
    localparam logic WSEL_DIR  = 1'b0;
    localparam logic WSEL_PORT = 1'b1;

    // read source select
    typedef enum logic [1:0] {
        RSEL_DIR  = 2'd0,
        RSEL_PORT = 2'd1,
        RSEL_PIN  = 2'd2,
        RSEL_NONE = 2'd3
    } rsel_e;
endpackage

// File: rtl/gpio_ovr_pinmux.sv
`timescale 1ns/1ps
module gpio_ovr_pinmux (
    input  logic dir_bit,
    input  logic port_bit,
    input  logic pud,
    input  logic sleep,
    input  logic pu_en,
    input  logic pu_val,
    input  logic dd_en,
    input  logic dd_val,
    input  logic pv_en,
    input  logic pv_val,
    input  logic ie_en,
    input  logic ie_val,
    output logic oe,
    output logic dout,
    output logic pu,
    output logic ie
);
    logic pu_default;

    always_comb begin
        // register-derived pull-up: input mode, port bit set, not globally disabled
        pu_default = ~dir_bit & port_bit & ~pud;
        pu   = pu_en ? pu_val : pu_default;
        oe   = dd_en ? dd_val : dir_bit;
        // value override only takes effect while the driver is on
        dout = (oe & pv_en) ? pv_val : port_bit;
        ie   = ie_en ? ie_val : ~sleep;
    end
endmodule

// File: rtl/gpio_ovr_sync.sv
`timescale 1ns/1ps
module gpio_ovr_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic             armed;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = din;
        st_d.s2    = st_q.s1;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

    // R10: each stage advances by exactly one edge
    p_stage1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (st_q.s1 == $past(din)));
    p_stage2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (dout == $past(st_q.s1)));
endmodule

// File: rtl/gpio_ovr_regs.sv
`timescale 1ns/1ps
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NPINS-1:0] wr_data,
    input  logic [NPINS-1:0] tgl,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    input  logic [NPINS-1:0] pin_level,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] port_q,
    output logic [NPINS-1:0] rd_data
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] port;
        logic [NPINS-1:0] rd;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_dir_hit, wr_port_hit;

    always_comb begin
        r_d         = r_q;
        wr_dir_hit  = wr_en && (wr_sel == WSEL_DIR);
        wr_port_hit = wr_en && (wr_sel == WSEL_PORT);
        if (wr_dir_hit)  r_d.dir  = wr_data;
        if (wr_port_hit) r_d.port = wr_data;
        // toggle applies on top of any same-cycle write
        r_d.port = r_d.port ^ tgl;
        if (rd_en) begin
            case (rsel_e'(rd_sel))
                RSEL_DIR:  r_d.rd = r_q.dir;
                RSEL_PORT: r_d.rd = r_q.port;
                RSEL_PIN:  r_d.rd = pin_level;
                default:   r_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_q   = r_q.dir;
    assign port_q  = r_q.port;
    assign rd_data = r_q.rd;

    // R2: registers are quiet without a write or toggle
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (tgl == '0)) |=> ((port_q == $past(port_q)) && (dir_q == $past(dir_q))));
    // R7: toggle alone inverts the stored bits
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel == WSEL_PORT)) |=> (port_q == ($past(port_q) ^ $past(tgl))));
    // R7: write and toggle together: write first, then invert
    p_wr_tgl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WSEL_PORT) |=> (port_q == ($past(wr_data) ^ $past(tgl))));
    // R11: read of direction returns the value present at the strobe
    p_rd_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd0) |=> (rd_data == $past(dir_q)));
    // R11: read data holds without a strobe
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/gpio_ovr_bank.sv
`timescale 1ns/1ps
module gpio_ovr_bank #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NPINS-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [NPINS-1:0] rd_data,
    input  logic             pud,
    input  logic             sleep,
    input  logic [NPINS-1:0] pu_ovr_en,
    input  logic [NPINS-1:0] pu_ovr_val,
    input  logic [NPINS-1:0] dd_ovr_en,
    input  logic [NPINS-1:0] dd_ovr_val,
    input  logic [NPINS-1:0] pv_ovr_en,
    input  logic [NPINS-1:0] pv_ovr_val,
    input  logic [NPINS-1:0] tgl_ovr_en,
    input  logic [NPINS-1:0] ie_ovr_en,
    input  logic [NPINS-1:0] ie_ovr_val,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_ie,
    output logic [NPINS-1:0] periph_in,
    output logic [NPINS-1:0] pin_sync
);
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] port_q;
    logic [NPINS-1:0] gated_in;

    gpio_ovr_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .tgl       (tgl_ovr_en),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .pin_level (pin_sync),
        .dir_q     (dir_q),
        .port_q    (port_q),
        .rd_data   (rd_data)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_ovr_pinmux u_mux (
            .dir_bit  (dir_q[g]),
            .port_bit (port_q[g]),
            .pud      (pud),
            .sleep    (sleep),
            .pu_en    (pu_ovr_en[g]),
            .pu_val   (pu_ovr_val[g]),
            .dd_en    (dd_ovr_en[g]),
            .dd_val   (dd_ovr_val[g]),
            .pv_en    (pv_ovr_en[g]),
            .pv_val   (pv_ovr_val[g]),
            .ie_en    (ie_ovr_en[g]),
            .ie_val   (ie_ovr_val[g]),
            .oe       (pad_oe[g]),
            .dout     (pad_out[g]),
            .pu       (pad_pu[g]),
            .ie       (pad_ie[g])
        );
    end

    // input gate sits ahead of the synchronizer; peripherals see it raw
    assign gated_in  = pad_in & pad_ie;
    assign periph_in = gated_in;

    gpio_ovr_sync #(.WIDTH(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gated_in),
        .dout  (pin_sync)
    );

    // R3: a default-path pull-up implies input mode, port set, pud clear
    p_pu_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & ~pu_ovr_en) & (dir_q | ~port_q | {NPINS{pud}})) == '0);
    // R5: without the override the driver follows the register
    p_oe_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ dir_q) & ~dd_ovr_en) == '0);
    // R6: a disabled driver never shows the override value in place of the port bit
    p_out_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ port_q) & ~pad_oe) == '0);
    // R8: a disabled input never reaches peripherals
    p_ie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_in & ~pad_ie) == '0);
    // R9: an enabled input passes through unchanged
    p_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_in ^ pad_in) & pad_ie) == '0);
endmodule

// File: tb/gpio_ovr_bank_test.sv
`timescale 1ns/1ps
module gpio_ovr_bank_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en, wr_sel, rd_en, pud, sleep;
    logic [1:0]   rd_sel;
    logic [N-1:0] wr_data, rd_data;
    logic [N-1:0] pu_ovr_en, pu_ovr_val, dd_ovr_en, dd_ovr_val;
    logic [N-1:0] pv_ovr_en, pv_ovr_val, tgl_ovr_en, ie_ovr_en, ie_ovr_val, pad_in;
    logic [N-1:0] pad_oe, pad_out, pad_pu, pad_ie, periph_in, pin_sync;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [N-1:0] dirv, portv, e_pu, e_oe, e_out, e_ie, e_per;

    always #2.5 clk = ~clk;

    gpio_ovr_bank #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .pud(pud), .sleep(sleep),
        .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val), .dd_ovr_en(dd_ovr_en),
        .dd_ovr_val(dd_ovr_val), .pv_ovr_en(pv_ovr_en), .pv_ovr_val(pv_ovr_val),
        .tgl_ovr_en(tgl_ovr_en), .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pad_ie(pad_ie), .periph_in(periph_in), .pin_sync(pin_sync)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not complete (actual hang, expected finish)");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic sel, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] sel);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_ovr();
        pu_ovr_en = '0; pu_ovr_val = '0; dd_ovr_en = '0; dd_ovr_val = '0;
        pv_ovr_en = '0; pv_ovr_val = '0; tgl_ovr_en = '0;
        ie_ovr_en = '0; ie_ovr_val = '0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        rd_en = 1'b0; rd_sel = 2'd0; pud = 1'b0; sleep = 1'b0; pad_in = 8'hFF;
        clear_ovr();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 pin_sync", pin_sync, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        pad_in = 8'h00;

        // R2 / R11: write then read back
        do_write(1'b0, 8'h3C);
        do_read(2'd0);
        chk("R2 dir readback", rd_data, 8'h3C);
        chk("R5 oe follows dir", pad_oe, 8'h3C);
        do_write(1'b1, 8'hA7);
        do_read(2'd1);
        chk("R2 port readback", rd_data, 8'hA7);
        do_write(1'b1, 8'h11);
        repeat (2) @(negedge clk);
        chk("R11 rd_data holds", rd_data, 8'hA7);
        do_read(2'd3);
        chk("R11 unused select", rd_data, 8'h00);
        do_read(2'd1);
        chk("R2 port rewrite", rd_data, 8'h11);

        // R3..R9: exhaustive per-pin sweep of the combinational controls
        for (int dp = 0; dp < 4; dp++) begin
            dirv  = ((dp & 1) != 0) ? 8'hA5 : 8'h5A;
            portv = ((dp & 2) != 0) ? 8'h33 : 8'hCC;
            do_write(1'b0, dirv);
            do_write(1'b1, portv);
            for (int v = 0; v < 2048; v++) begin
                pud   = v[0];
                sleep = v[1];
                for (int i = 0; i < N; i++) begin
                    int k;
                    k = ((v >> 2) + i * 53) % 512;
                    pu_ovr_en[i]  = k[0]; pu_ovr_val[i] = k[1];
                    dd_ovr_en[i]  = k[2]; dd_ovr_val[i] = k[3];
                    pv_ovr_en[i]  = k[4]; pv_ovr_val[i] = k[5];
                    ie_ovr_en[i]  = k[6]; ie_ovr_val[i] = k[7];
                    pad_in[i]     = k[8];
                    e_pu[i]  = k[0] ? k[1] : (!dirv[i] && portv[i] && !v[0]);
                    e_oe[i]  = k[2] ? k[3] : dirv[i];
                    e_out[i] = (e_oe[i] && k[4]) ? k[5] : portv[i];
                    e_ie[i]  = k[6] ? k[7] : !v[1];
                    e_per[i] = k[8] && e_ie[i];
                end
                #1;
                chk("R3/R4 pad_pu", pad_pu, e_pu);
                chk("R5 pad_oe", pad_oe, e_oe);
                chk("R6 pad_out", pad_out, e_out);
                chk("R8 pad_ie", pad_ie, e_ie);
                chk("R9 periph_in", periph_in, e_per);
            end
        end
        clear_ovr();
        pud = 1'b0; sleep = 1'b0; pad_in = 8'h00;

        // R7: toggle behaviour, observed on pad_out with no value override
        do_write(1'b1, 8'h0F);
        @(negedge clk); tgl_ovr_en = 8'h81;
        @(negedge clk); tgl_ovr_en = 8'h00;
        chk("R7 single toggle", pad_out, 8'h8E);
        @(negedge clk); tgl_ovr_en = 8'h03;
        repeat (3) @(negedge clk);
        tgl_ovr_en = 8'h00;
        chk("R7 held toggle x3", pad_out, 8'h8D);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h55; tgl_ovr_en = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; tgl_ovr_en = 8'h00;
        chk("R7 toggle after write", pad_out, 8'h54);
        repeat (2) @(negedge clk);
        chk("R2 port holds", pad_out, 8'h54);

        // R10: two-edge synchronizer latency
        repeat (3) @(negedge clk);
        chk("R10 settled low", pin_sync, 8'h00);
        pad_in = 8'h96;
        #0.1;
        chk("R9 immediate periph_in", periph_in, 8'h96);
        @(negedge clk);
        chk("R10 after one edge", pin_sync, 8'h00);
        @(negedge clk);
        chk("R10 after two edges", pin_sync, 8'h96);
        do_read(2'd2);
        chk("R11 pin read", rd_data, 8'h96);

        // R8: sleep gates input, override reopens selected pins
        @(negedge clk); sleep = 1'b1;
        #0.1;
        chk("R8 sleep ie off", pad_ie, 8'h00);
        chk("R8 sleep periph zero", periph_in, 8'h00);
        repeat (2) @(negedge clk);
        chk("R8 sleep pin_sync zero", pin_sync, 8'h00);
        ie_ovr_en = 8'h0F; ie_ovr_val = 8'h05;
        #0.1;
        chk("R8 override in sleep", pad_ie, 8'h05);
        chk("R8 periph gated", periph_in, 8'h04);
        repeat (2) @(negedge clk);
        chk("R8 pin_sync gated", pin_sync, 8'h04);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule